// File: doc/BRIEF.md
# Linked Context Save Sequencer

This block carries out subroutine call and return for a processor core. The caller's upper register context is kept in sixteen-word frames in memory. Unused frames sit on a free list whose head is a 20-bit link held in the block. A call takes the frame at the head of the free list and stores the current context into it. It then pushes that frame onto the saved-context chain through the previous-context word. A return reads the newest frame back into the registers and puts the frame back at the head of the free list.

The block owns the free-list head, a limit link, the previous-context word, a status word with an embedded call-depth counter, an interrupt control word (priority and enable) and the fourteen general context registers. The core fills these registers through a plain load port. Memory is reached through a single-word valid/ready port. A request stays asserted, with its address, direction and write data unchanged, until `mem_ready` is seen high. The transfer completes in the cycle where both `mem_valid` and `mem_ready` are high. For a read, `mem_rdata` must be valid in that same cycle. The memory may hold `mem_ready` low for any number of cycles to stall the block.

Error conditions do not stop an operation. Each one is reported as a one-cycle trap flag that rises together with `done`, and the operation still completes.

Top module: `ctx_chain_seq`

## Requirements
- R1: Frame word k of a frame whose 20-bit link is L is accessed at an address built as follows. L[19:16] goes to address bits 31:28. L[15:0] goes to address bits 21:6. k goes to address bits 5:2. Every other address bit is zero.
- R2: A call first reads word 0 of the head frame, which holds the next free link. It then writes 16 words to that frame in this order: previous-context word, status word, and then context registers 0..13 (register 1 holds the return address).
- R3: At the end of a call, the previous-context word is rebuilt as follows. Bits 31:24 take interrupt-control bits 7:0 (the priority). Bit 23 takes interrupt-control bit 8 (the enable). Bit 22, the upper-context flag, is set. Bits 19:0 take the old head link. The head's bits 19:0 take the next free link, and its upper bits are kept. Context register 1 takes `ret_addr`.
- R4: Status bits 6:0 form the call-depth field, and status bit 7 enables counting. The value 7'h7F means the field is not counted. Otherwise the leading ones of the field set the width of the count, which is the bits below them. A call with counting enabled increments the field. If the count wraps to zero, the old field is kept and `trap_depth_ovf` is raised. After the call, bit 7 is set.
- R5: A return with counting enabled and a zero count raises `trap_depth_unf`. A field of 7'h7F never raises it.
- R6: A return raises `trap_chain_empty` when bits 19:0 of the previous-context word are zero. It raises `trap_ctx_type` when the upper-context flag (bit 22) is clear.
- R7: A return sets `pc_o` to context register 1 with bit 0 cleared. It then reads the 16 frame words in order: word 0 becomes the new previous-context word, word 1 becomes the new status, and words 2..15 become registers 0..13. Finally it writes the old head into word 0, and the head's bits 19:0 take the old previous-context bits 19:0.
- R8: A call raises `trap_free_empty` when the head is zero. It raises `trap_free_last` when the head equals the limit.
- R9: `busy` is high from the cycle after an accepted request through the `done` cycle. `done` is a one-cycle pulse. Requests seen while `busy` is high are ignored. A call and a return requested in the same cycle start a call.
- R10: Trap flags are high only in the `done` cycle, and an operation that traps still performs all its transfers and register updates.
- R11: The load port writes while idle, and loads seen while busy are ignored. `wr_sel` values 0..13 select context registers 0..13. Values 16, 17, 18, 19 and 20 select the head, the limit, the previous-context word, the status and the interrupt control. `rd_data` returns context register `rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_req | input | 1 | Start a call (single-cycle request) |
| ret_req | input | 1 | Start a return (single-cycle request) |
| ret_addr | input | 32 | Return address stored into context register 1 on a call |
| wr_en | input | 1 | Load-port write strobe |
| wr_sel | input | 5 | Load-port register select |
| wr_data | input | 32 | Load-port data |
| rd_sel | input | 4 | Context register read select |
| rd_data | output | 32 | Selected context register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished this cycle |
| pc_o | output | 32 | Program counter set by a return |
| head_o | output | 32 | Free-list head |
| limit_o | output | 32 | Free-list limit |
| link_o | output | 32 | Previous-context word |
| status_o | output | 32 | Status word with depth field |
| intr_o | output | 32 | Interrupt control word |
| trap_free_empty | output | 1 | Call with empty free list |
| trap_free_last | output | 1 | Call consumed the limit frame |
| trap_depth_ovf | output | 1 | Call depth overflow |
| trap_depth_unf | output | 1 | Call depth underflow |
| trap_chain_empty | output | 1 | Return with empty chain |
| trap_ctx_type | output | 1 | Return into a frame without the upper-context flag |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts / completes the transfer |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address of the transfer |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |

## Verification
Two traps from different sources can fall in the same `done` cycle. A call made with the head equal to the limit and a depth field of 7'h3F, counting enabled, must raise both free-list depletion and depth overflow. The status must come back unchanged and the head must advance. A return from an empty chain raises the chain and context-type traps together. Call and return requests in the same cycle are judged by the transfer log: the second transfer must be a write, which proves that a call started. A return and a load that arrive during a stalled operation must leave no trace in the transfer count or in the limit.

// File: rtl/ctx_seq_pkg.sv
package ctx_seq_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned LINK_W      = 20;
  localparam int unsigned SEG_W       = 4;
  localparam int unsigned FRAME_WORDS = 16;
  localparam int unsigned HDR_WORDS   = 2;
  localparam int unsigned DEPTH_W     = 7;
  localparam int unsigned DEPTH_EN    = 7;
  localparam int unsigned PRIO_W      = 8;
  localparam int unsigned IE_BIT      = 8;
  localparam int unsigned PIE_BIT     = 23;
  localparam int unsigned UL_BIT      = 22;
  localparam int unsigned RA_IDX      = 1;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_LINK, S_WR_CTX, S_RD_CTX, S_WR_LINK, S_FIN
  } seq_state_e;

  typedef struct packed {
    logic free_empty;
    logic free_last;
    logic depth_ovf;
    logic depth_unf;
    logic chain_empty;
    logic ctx_type;
  } trap_t;
endpackage

// File: rtl/ctx_frame_addr.sv
module ctx_frame_addr #(
  parameter int unsigned AW     = 32,
  parameter int unsigned LINK_W = 20,
  parameter int unsigned SEG_W  = 4,
  parameter int unsigned IDX_W  = 4
) (
  input  logic [LINK_W-1:0] link,
  input  logic [IDX_W-1:0]  word_idx,
  output logic [AW-1:0]     addr
);
  localparam int unsigned OFF_W   = LINK_W - SEG_W;
  localparam int unsigned OFF_LSB = IDX_W + 2;

  always_comb begin
    addr = '0;
    addr[AW-1 -: SEG_W]     = link[LINK_W-1 -: SEG_W];
    addr[OFF_LSB +: OFF_W]  = link[OFF_W-1:0];
    addr[2 +: IDX_W]        = word_idx;
  end
endmodule

// File: rtl/ctx_depth_unit.sv
module ctx_depth_unit #(
  parameter int unsigned W = 7
) (
  input  logic [W-1:0] cnt_field,
  input  logic         up,
  output logic [W-1:0] next_field,
  output logic         fault
);
  // Mask of the count bits: everything below the leading ones.
  function automatic logic [W-1:0] count_mask(input logic [W-1:0] v);
    int unsigned ones;
    logic        run;
    ones = 0;
    run  = 1'b1;
    for (int i = W - 1; i >= 0; i--) begin
      if (run && v[i]) ones++;
      else run = 1'b0;
    end
    return W'((33'd1 << (W - ones)) - 33'd1);
  endfunction

  logic [W-1:0] bumped, dropped;
  logic         frozen;

  always_comb begin
    bumped  = cnt_field + W'(1);
    dropped = cnt_field - W'(1);
    frozen  = &cnt_field;
    if (up) fault = !frozen && ((bumped & count_mask(bumped)) == '0);
    else    fault = !frozen && ((cnt_field & count_mask(cnt_field)) == '0);
    if (frozen || fault) next_field = cnt_field;
    else                 next_field = up ? bumped : dropped;
  end
endmodule

// File: rtl/ctx_chain_seq.sv
module ctx_chain_seq
  import ctx_seq_pkg::*;
#(
  parameter int unsigned XLEN      = WORD_W,
  parameter int unsigned LINK_BITS = LINK_W,
  parameter int unsigned SEG_BITS  = SEG_W,
  parameter int unsigned NWORDS    = FRAME_WORDS,
  parameter int unsigned CNT_BITS  = DEPTH_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          call_req,
  input  logic                          ret_req,
  input  logic [XLEN-1:0]               ret_addr,
  input  logic                          wr_en,
  input  logic [$clog2(NWORDS):0]       wr_sel,
  input  logic [XLEN-1:0]               wr_data,
  input  logic [$clog2(NWORDS)-1:0]     rd_sel,
  output logic [XLEN-1:0]               rd_data,
  output logic                          busy,
  output logic                          done,
  output logic [XLEN-1:0]               pc_o,
  output logic [XLEN-1:0]               head_o,
  output logic [XLEN-1:0]               limit_o,
  output logic [XLEN-1:0]               link_o,
  output logic [XLEN-1:0]               status_o,
  output logic [XLEN-1:0]               intr_o,
  output logic                          trap_free_empty,
  output logic                          trap_free_last,
  output logic                          trap_depth_ovf,
  output logic                          trap_depth_unf,
  output logic                          trap_chain_empty,
  output logic                          trap_ctx_type,
  output logic                          mem_valid,
  input  logic                          mem_ready,
  output logic                          mem_we,
  output logic [XLEN-1:0]               mem_addr,
  output logic [XLEN-1:0]               mem_wdata,
  input  logic [XLEN-1:0]               mem_rdata
);
  localparam int unsigned IDX_W  = $clog2(NWORDS);
  localparam int unsigned SEL_W  = IDX_W + 1;
  localparam int unsigned NREGS  = NWORDS - HDR_WORDS;
  localparam logic [SEL_W-1:0] SEL_HEAD  = SEL_W'(NWORDS);
  localparam logic [SEL_W-1:0] SEL_LIMIT = SEL_W'(NWORDS + 1);
  localparam logic [SEL_W-1:0] SEL_LINK  = SEL_W'(NWORDS + 2);
  localparam logic [SEL_W-1:0] SEL_STAT  = SEL_W'(NWORDS + 3);
  localparam logic [SEL_W-1:0] SEL_INTR  = SEL_W'(NWORDS + 4);
  localparam logic [IDX_W-1:0] LAST_W    = IDX_W'(NWORDS - 1);

  seq_state_e           st_q;
  logic                 is_call_q;
  logic [IDX_W-1:0]     widx_q;
  logic [LINK_BITS-1:0] base_q, nlink_q;
  logic [XLEN-1:0]      head_q, limit_q, link_q, stat_q, intr_q, pc_q;
  logic [XLEN-1:0]      ret_addr_q, stat_new_q, hdr_link_q, hdr_stat_q;
  logic [XLEN-1:0]      ctx_q [NREGS];
  trap_t                trap_q;

  logic [CNT_BITS-1:0]  depth_next;
  logic                 depth_fault, count_en, xfer;
  logic [XLEN-1:0]      stat_call, link_call;

  ctx_depth_unit #(.W(CNT_BITS)) u_depth (
    .cnt_field (stat_q[CNT_BITS-1:0]),
    .up        (call_req),
    .next_field(depth_next),
    .fault     (depth_fault)
  );

  ctx_frame_addr #(.AW(XLEN), .LINK_W(LINK_BITS), .SEG_W(SEG_BITS), .IDX_W(IDX_W)) u_addr (
    .link    (base_q),
    .word_idx(widx_q),
    .addr    (mem_addr)
  );

  assign count_en = stat_q[DEPTH_EN];
  assign xfer     = mem_valid && mem_ready;

  always_comb begin
    stat_call = stat_q;
    if (count_en) stat_call[CNT_BITS-1:0] = depth_next;
    stat_call[DEPTH_EN] = 1'b1;
    link_call = link_q;
    link_call[XLEN-1 -: PRIO_W]   = intr_q[PRIO_W-1:0];
    link_call[PIE_BIT]            = intr_q[IE_BIT];
    link_call[UL_BIT]             = 1'b1;
    link_call[LINK_BITS-1:0]      = base_q;
  end

  always_comb begin
    mem_valid = (st_q == S_RD_LINK) || (st_q == S_WR_CTX) ||
                (st_q == S_RD_CTX)  || (st_q == S_WR_LINK);
    mem_we    = (st_q == S_WR_CTX) || (st_q == S_WR_LINK);
    mem_wdata = '0;
    if (st_q == S_WR_LINK)          mem_wdata = head_q;
    else if (st_q == S_WR_CTX) begin
      if (widx_q == '0)             mem_wdata = link_q;
      else if (widx_q == IDX_W'(1)) mem_wdata = stat_q;
      else                          mem_wdata = ctx_q[widx_q - IDX_W'(HDR_WORDS)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  is_call_q <= 1'b0;  widx_q <= '0;
      base_q <= '0;    nlink_q <= '0;      trap_q <= '0;
      head_q <= '0;    limit_q <= '0;      link_q <= '0;
      stat_q <= '0;    intr_q <= '0;       pc_q <= '0;
      ret_addr_q <= '0; stat_new_q <= '0;  hdr_link_q <= '0; hdr_stat_q <= '0;
      for (int i = 0; i < int'(NREGS); i++) ctx_q[i] <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (wr_en) begin
            if (wr_sel < SEL_W'(NREGS)) ctx_q[wr_sel[IDX_W-1:0]] <= wr_data;
            else if (wr_sel == SEL_HEAD)  head_q  <= wr_data;
            else if (wr_sel == SEL_LIMIT) limit_q <= wr_data;
            else if (wr_sel == SEL_LINK)  link_q  <= wr_data;
            else if (wr_sel == SEL_STAT)  stat_q  <= wr_data;
            else if (wr_sel == SEL_INTR)  intr_q  <= wr_data;
          end
          widx_q <= '0;
          if (call_req) begin
            is_call_q   <= 1'b1;
            base_q      <= head_q[LINK_BITS-1:0];
            ret_addr_q  <= ret_addr;
            stat_new_q  <= stat_call;
            trap_q      <= '0;
            trap_q.free_empty <= (head_q == '0);
            trap_q.free_last  <= (head_q == limit_q);
            trap_q.depth_ovf  <= count_en && depth_fault;
            st_q        <= S_RD_LINK;
          end else if (ret_req) begin
            is_call_q   <= 1'b0;
            base_q      <= link_q[LINK_BITS-1:0];
            pc_q        <= ctx_q[RA_IDX] & ~XLEN'(1);
            trap_q      <= '0;
            trap_q.depth_unf   <= count_en && depth_fault;
            trap_q.chain_empty <= (link_q[LINK_BITS-1:0] == '0);
            trap_q.ctx_type    <= !link_q[UL_BIT];
            st_q        <= S_RD_CTX;
          end
        end
        S_RD_LINK: if (xfer) begin
          nlink_q <= mem_rdata[LINK_BITS-1:0];
          st_q    <= S_WR_CTX;
        end
        S_WR_CTX: if (xfer) begin
          if (widx_q == LAST_W) st_q <= S_FIN;
          else widx_q <= widx_q + IDX_W'(1);
        end
        S_RD_CTX: if (xfer) begin
          if (widx_q == '0)             hdr_link_q <= mem_rdata;
          else if (widx_q == IDX_W'(1)) hdr_stat_q <= mem_rdata;
          else ctx_q[widx_q - IDX_W'(HDR_WORDS)] <= mem_rdata;
          if (widx_q == LAST_W) begin
            st_q   <= S_WR_LINK;
            widx_q <= '0;
          end else widx_q <= widx_q + IDX_W'(1);
        end
        S_WR_LINK: if (xfer) st_q <= S_FIN;
        default: begin
          st_q <= S_IDLE;
          if (is_call_q) begin
            link_q         <= link_call;
            head_q         <= {head_q[XLEN-1:LINK_BITS], nlink_q};
            ctx_q[RA_IDX]  <= ret_addr_q;
            stat_q         <= stat_new_q;
          end else begin
            head_q <= {head_q[XLEN-1:LINK_BITS], link_q[LINK_BITS-1:0]};
            link_q <= hdr_link_q;
            stat_q <= hdr_stat_q;
          end
        end
      endcase
    end
  end

  assign busy     = (st_q != S_IDLE);
  assign done     = (st_q == S_FIN);
  assign rd_data  = (rd_sel < IDX_W'(NREGS)) ? ctx_q[rd_sel] : '0;
  assign pc_o     = pc_q;
  assign head_o   = head_q;
  assign limit_o  = limit_q;
  assign link_o   = link_q;
  assign status_o = stat_q;
  assign intr_o   = intr_q;
  assign trap_free_empty  = done && trap_q.free_empty;
  assign trap_free_last   = done && trap_q.free_last;
  assign trap_depth_ovf   = done && trap_q.depth_ovf;
  assign trap_depth_unf   = done && trap_q.depth_unf;
  assign trap_chain_empty = done && trap_q.chain_empty;
  assign trap_ctx_type    = done && trap_q.ctx_type;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy); // R9
  AST_TRAP_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_free_empty || trap_free_last || trap_depth_ovf || trap_depth_unf ||
     trap_chain_empty || trap_ctx_type) |-> done); // R10
  AST_ADDR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[27:22] == '0 && mem_addr[1:0] == '0)); // R1
  AST_UL_AFTER_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_call_q) |=> link_q[UL_BIT]); // R3
endmodule

// File: tb/ctx_chain_seq_test.sv
module ctx_chain_seq_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        call_req = 0, ret_req = 0, wr_en = 0, mem_ready = 0;
  logic [31:0] ret_addr = 0, wr_data = 0, mem_rdata = 0;
  logic [4:0]  wr_sel = 0;
  logic [3:0]  rd_sel = 0;
  logic [31:0] rd_data, pc_o, head_o, limit_o, link_o, status_o, intr_o, mem_addr, mem_wdata;
  logic        busy, done, mem_valid, mem_we;
  logic        trap_free_empty, trap_free_last, trap_depth_ovf, trap_depth_unf, trap_chain_empty, trap_ctx_type;

  int n_chk = 0, n_fail = 0;
  logic [31:0] bmem [0:1023];
  logic [31:0] log_addr [0:31];
  logic [31:0] log_data [0:31];
  logic        log_we   [0:31];
  int          log_n = 0;
  logic        stall_on = 0, tick = 0;
  logic [5:0]  tv;

  always #5 clk = ~clk;

  ctx_chain_seq uut (.*);

  // Memory responder: decides ready at each falling edge; transfer completes at the next rising edge.
  initial begin
    for (int i = 0; i < 1024; i++) bmem[i] = '0;
    forever begin
      @(negedge clk);
      tick = ~tick;
      if (mem_valid && (!stall_on || tick)) begin
        mem_ready = 1'b1;
        mem_rdata = bmem[mem_addr[11:2]];
        if (log_n < 32) begin
          log_addr[log_n] = mem_addr; log_data[log_n] = mem_we ? mem_wdata : mem_rdata;
          log_we[log_n] = mem_we; log_n++;
        end
        if (mem_we) bmem[mem_addr[11:2]] = mem_wdata;
      end else mem_ready = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [4:0] sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic get_reg(input logic [3:0] idx, output logic [31:0] d);
    @(negedge clk); rd_sel = idx; #1 d = rd_data;
  endtask

  // Runs one operation; poke = disturb the block while busy.
  task automatic run_op(input logic c, input logic r, input logic [31:0] ra, input logic poke);
    logic got;
    @(negedge clk);
    call_req = c; ret_req = r; ret_addr = ra; log_n = 0; tv = '0;
    @(negedge clk);
    call_req = 0; ret_req = 0;
    if (poke) begin
      chk("R9 busy after request", {31'd0, busy}, 32'd1);
      ret_req = 1; wr_en = 1; wr_sel = 5'd17; wr_data = 32'h7;
      @(negedge clk);
      ret_req = 0; wr_en = 0;
    end
    got = 0;
    while (!got) begin
      if (done) begin
        got = 1;
        tv = {trap_free_empty, trap_free_last, trap_depth_ovf, trap_depth_unf, trap_chain_empty, trap_ctx_type};
      end else @(negedge clk);
    end
    @(negedge clk);
    chk("R10 traps low after done", {26'd0, trap_free_empty, trap_free_last, trap_depth_ovf,
        trap_depth_unf, trap_chain_empty, trap_ctx_type}, 32'd0);
    chk("R9 idle after done", {30'd0, busy, done}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R9 reset busy", {31'd0, busy}, 0);
    chk("R9 reset done", {31'd0, done}, 0);
    chk("R11 reset head", head_o, 0);
    chk("R9 reset mem_valid", {31'd0, mem_valid}, 0);
  endtask

  task automatic t_setup;
    logic [31:0] d;
    for (int k = 0; k < 14; k++) load(5'(k), 32'h1000 + k);
    load(5'd16, 32'h1); load(5'd17, 32'h3); load(5'd18, 32'h0);
    load(5'd19, 32'h0); load(5'd20, 32'h105);
    bmem[16] = 32'h2; bmem[32] = 32'h3; bmem[48] = 32'h0;
    get_reg(4'd5, d);
    chk("R11 load ctx reg 5", d, 32'h1005);
    chk("R11 load intr", intr_o, 32'h105);
  endtask

  task automatic t_call_basic;
    run_op(1, 0, 32'h2001, 0);
    chk("R2 call transfer count", log_n, 17);
    chk("R1 link read address", log_addr[0], 32'h40);
    chk("R2 first is read", {31'd0, log_we[0]}, 0);
    chk("R1 last word address", log_addr[16], 32'h7C);
    chk("R2 word0 prev-context", log_data[1], 32'h0);
    chk("R2 word1 status", log_data[2], 32'h0);
    for (int k = 3; k <= 16; k++) chk("R2 ctx word order", log_data[k], 32'h1000 + k - 3);
    chk("R3 link after call", link_o, 32'h05C00001);
    chk("R3 head after call", head_o, 32'h2);
    chk("R4 enable set, no count", status_o, 32'h80);
    chk("R8 no traps", {26'd0, tv}, 0);
  endtask

  task automatic t_call_count;
    logic [31:0] d;
    load(5'd20, 32'h007);
    run_op(1, 0, 32'h2002, 0);
    chk("R2 stored prev-context", log_data[1], 32'h05C00001);
    chk("R2 stored old status", log_data[2], 32'h80);
    chk("R4 depth incremented", status_o, 32'h81);
    chk("R3 link priority/no PIE", link_o, 32'h07400002);
    chk("R3 head advanced", head_o, 32'h3);
    get_reg(4'd1, d);
    chk("R3 return address", d, 32'h2002);
  endtask

  task automatic t_call_double_trap;
    load(5'd19, 32'hBF);
    run_op(1, 0, 32'h3003, 0);
    chk("R8 R4 depletion + overflow", {26'd0, tv}, 32'b011000);
    chk("R4 overflow keeps status", status_o, 32'hBF);
    chk("R10 head still advanced", head_o, 32'h0);
    chk("R10 link still updated", link_o, 32'h07400003);
  endtask

  task automatic t_returns;
    logic [31:0] d;
    run_op(0, 1, 0, 0);
    chk("R7 ret transfer count", log_n, 17);
    chk("R7 pc from A11", pc_o, 32'h3002);
    chk("R7 head write-back addr", log_addr[16], 32'hC0);
    chk("R7 head write-back data", log_data[16], 32'h0);
    chk("R7 head from link", head_o, 32'h3);
    chk("R7 restored link", link_o, 32'h07400002);
    chk("R7 restored status", status_o, 32'hBF);
    get_reg(4'd1, d);
    chk("R7 restored A11", d, 32'h2002);
    chk("R5 no underflow", {26'd0, tv}, 0);
    load(5'd19, 32'hC0);
    run_op(0, 1, 0, 0);
    chk("R5 depth underflow", {26'd0, tv}, 32'b000100);
    chk("R10 status restored after trap", status_o, 32'h80);
    chk("R7 head", head_o, 32'h2);
    load(5'd19, 32'h00);
    run_op(0, 1, 0, 0);
    chk("R5 disabled no trap", {26'd0, tv}, 0);
    chk("R7 pc bit0 cleared", pc_o, 32'h2000);
    chk("R7 free word0 restored", bmem[16], 32'h2);
    run_op(0, 1, 0, 0);
    chk("R6 chain empty + type", {26'd0, tv}, 32'b000011);
    chk("R6 pc", pc_o, 32'h1000);
  endtask

  task automatic t_call_empty_busy;
    load(5'd19, 32'hFF); load(5'd17, 32'h5);
    run_op(1, 0, 32'h5005, 1);
    chk("R8 free empty", {26'd0, tv}, 32'b100000);
    chk("R4 frozen field", status_o, 32'hFF);
    chk("R9 ret ignored while busy", log_n, 17);
    chk("R11 load ignored while busy", limit_o, 32'h5);
    chk("R3 head from link", head_o, 32'h1);
    chk("R3 link", link_o, 32'h07400000);
  endtask

  task automatic t_call_segment;
    load(5'd16, 32'h00030002);
    stall_on = 1;
    run_op(1, 1, 32'h6006, 0);
    stall_on = 0;
    chk("R1 segment address", log_addr[0], 32'h30000080);
    chk("R1 segment last addr", log_addr[16], 32'h300000BC);
    chk("R9 call wins", {31'd0, log_we[1]}, 1);
    chk("R9 stalled count", log_n, 17);
    chk("R3 head keeps upper", head_o, 32'h3);
    chk("R3 link low link", link_o, 32'h07430002);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_setup;
    t_call_basic;
    t_call_count;
    t_call_double_trap;
    t_returns;
    t_call_empty_busy;
    t_call_segment;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule